// File: doc/BRIEF.md
# Transactional Conflict Tracker

This block keeps the per-node bookkeeping of a hardware transactional memory that buffers speculative data in a private snooping cache, detects conflicts as soon as coherence responses reveal them, and resolves them only when some transaction ends. For every cache line it holds three flags: speculatively read, speculatively written, and read-with-conflict. It also holds a killer map with one bit per node. A set bit means the local transaction must die if that node commits first.

The core presents each transactional load or store together with the snoop result for that access. If the snoop found the line modified at another node, the access carries a write-conflict indication and the responding node's number. The bus side presents the commit and abort broadcasts of every node. When the local transaction ends, either by its own request or because a recorded killer committed, the block does three things. It issues one end message, clears the killer map, and walks the line flags one line per cycle. During that walk it strobes an invalidate for each line that has to be discarded and clears the flags of every line. A probe port lets the cache controller read the flags of any line.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset the killer map is zero, all line flags read zero on the probe port, and `busy`, `kill_abort`, `msg_valid` and `inv_valid` are low.
- R2: An accepted load sets the read flag of its line, and an accepted store sets the write flag. The change is visible on the probe port from the cycle after acceptance.
- R3: An accepted access with `acc_wconf` high sets killer-map bit `acc_wconf_node` (bit i stands for node i). If that access is a load, it also sets the line's conflict flag. A store leaves the conflict flag alone.
- R4: A bus commit (`bus_is_commit`=1) from node N while killer bit N is set ends the transaction as an abort. The next cycle shows `kill_abort`=1 and an abort message. A bus commit from a node whose bit is clear has no visible effect.
- R5: A bus abort (`bus_is_commit`=0) from node N clears killer bit N. If an accepted access sets the same bit in the same cycle, the bit ends up set.
- R6: Bus messages carrying this node's own number (`NODE_ID`) are ignored, and the killer bit for `NODE_ID` is never set.
- R7: A transaction end produces exactly one `msg_valid` pulse, in the cycle after the end is decided. `msg_is_commit` is 1 for a commit and 0 for an abort. A simultaneous commit and abort request counts as an abort.
- R8: The end sweep visits lines 0 to LINES-1 in ascending order, one per cycle, with `inv_line` giving the line. On a commit it strobes `inv_valid` only for lines whose conflict flag is set. On an abort it strobes lines whose write flag or conflict flag is set.
- R9: When `busy` falls, every read, write and conflict flag and the whole killer map are zero.
- R10: `busy` stays high for exactly LINES cycles after an end. While `busy` is high, accesses and end requests have no effect. An access presented in the cycle an end is decided is also dropped.
- R11: If a killing bus commit arrives in the same cycle as a local commit request, the transaction aborts: `msg_is_commit`=0 and `kill_abort`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Transactional access presented |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_line | input | $clog2(LINES) | Line index of the access |
| acc_wconf | input | 1 | Snoop returned a write conflict for this access |
| acc_wconf_node | input | $clog2(NODES) | Node that holds the line modified |
| end_commit | input | 1 | Local request to commit |
| end_abort | input | 1 | Local request to abort |
| bus_valid | input | 1 | Bus end message observed |
| bus_is_commit | input | 1 | 1 = commit message, 0 = abort message |
| bus_node | input | $clog2(NODES) | Sender of the bus message |
| probe_line | input | $clog2(LINES) | Line whose flags are read out |
| probe_sr | output | 1 | Read flag of the probed line |
| probe_sw | output | 1 | Write flag of the probed line |
| probe_rc | output | 1 | Conflict flag of the probed line |
| killers | output | NODES | Killer map |
| kill_abort | output | 1 | Pulse: transaction killed by a remote commit |
| busy | output | 1 | End sweep in progress |
| inv_valid | output | 1 | Invalidate strobe for `inv_line` |
| inv_line | output | $clog2(LINES) | Line currently swept |
| msg_valid | output | 1 | Pulse: send end message on the bus |
| msg_is_commit | output | 1 | Kind of end message |

## Verification
A flag left set or cleared wrongly stays hidden until the next end sweep. At that point it shows up as a missing or extra `inv_valid` strobe at a specific `inv_line`. Some faults show earlier: the probe port exposes them from the cycle after the access that caused them. A wrong killer bit shows on `killers` at once, and it turns a harmless remote commit into a spurious `kill_abort` one cycle later, or lets a real one pass unnoticed. A reference model therefore compares every output and the probed flags on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int NODES   = 4,
  parameter int NODE_ID = 1,
  parameter int LINES   = 8,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [LW-1:0] acc_line,
  input  logic          acc_wconf,
  input  logic [NW-1:0] acc_wconf_node,
  input  logic          end_commit,
  input  logic          end_abort,
  input  logic          bus_valid,
  input  logic          bus_is_commit,
  input  logic [NW-1:0] bus_node,
  input  logic [LW-1:0] probe_line,
  output logic          probe_sr,
  output logic          probe_sw,
  output logic          probe_rc,
  output logic [NODES-1:0] killers,
  output logic          kill_abort,
  output logic          busy,
  output logic          inv_valid,
  output logic [LW-1:0] inv_line,
  output logic          msg_valid,
  output logic          msg_is_commit
);

  logic [LINES-1:0] sr, sw, rc;
  logic [NODES-1:0] kmap, kmap_nxt;
  logic [LW-1:0]    ptr;
  logic             sweep_abort;

  wire remote   = bus_valid && (int'(bus_node) != NODE_ID) && (int'(bus_node) < NODES);
  wire killed   = !busy && remote && bus_is_commit && kmap[bus_node];
  wire fin_ab   = !busy && (end_abort || killed);
  wire fin_cm   = !busy && end_commit && !fin_ab;
  wire finish   = fin_ab || fin_cm;
  wire take     = acc_valid && !busy && !finish;
  wire mark     = take && acc_wconf && (int'(acc_wconf_node) != NODE_ID)
                  && (int'(acc_wconf_node) < NODES);
  wire last     = (int'(ptr) == LINES - 1);

  wire [LINES-1:0] acc_hot = LINES'(1) << acc_line;
  wire [LINES-1:0] ptr_hot = LINES'(1) << ptr;

  always_comb begin
    kmap_nxt = kmap;
    if (remote && !bus_is_commit) kmap_nxt[bus_node] = 1'b0;
    if (mark) kmap_nxt[acc_wconf_node] = 1'b1;
    if (finish) kmap_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
      sw <= '0;
      rc <= '0;
      kmap <= '0;
      ptr <= '0;
      busy <= 1'b0;
      sweep_abort <= 1'b0;
      msg_valid <= 1'b0;
      msg_is_commit <= 1'b0;
      kill_abort <= 1'b0;
    end else begin
      kmap <= kmap_nxt;
      msg_valid <= finish;
      msg_is_commit <= fin_cm;
      kill_abort <= killed;
      if (busy) begin
        sr <= sr & ~ptr_hot;
        sw <= sw & ~ptr_hot;
        rc <= rc & ~ptr_hot;
        if (last) busy <= 1'b0;
        else ptr <= ptr + 1'b1;
      end else if (finish) begin
        busy <= 1'b1;
        ptr <= '0;
        sweep_abort <= fin_ab;
      end else if (take) begin
        if (acc_store) sw <= sw | acc_hot;
        else sr <= sr | acc_hot;
        if (mark && !acc_store) rc <= rc | acc_hot;
      end
    end
  end

  assign killers   = kmap;
  assign probe_sr  = sr[probe_line];
  assign probe_sw  = sw[probe_line];
  assign probe_rc  = rc[probe_line];
  assign inv_line  = ptr;
  assign inv_valid = busy && (rc[ptr] || (sweep_abort && sw[ptr]));

  // R7
  msg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  // R4
  kill_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_abort |-> (msg_valid && !msg_is_commit && busy));

  // R9
  clean_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sr == '0 && sw == '0 && rc == '0 && kmap == '0));

  // R10
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'($past(ptr)) == LINES - 1));

  // R3
  rc_has_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((rc & ~sr) == '0));

  // R6
  self_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kmap[NODE_ID]);

endmodule

// File: tb/sim_txn_conflict_tracker.sv
module sim_txn_conflict_tracker;
  localparam int NODES = 4, ID = 1, LINES = 8;
  localparam int NW = 2, LW = 3;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_store = 0, acc_wconf = 0;
  logic [LW-1:0] acc_line = 0, probe_line = 0;
  logic [NW-1:0] acc_wconf_node = 0, bus_node = 0;
  logic end_commit = 0, end_abort = 0, bus_valid = 0, bus_is_commit = 0;
  logic probe_sr, probe_sw, probe_rc, kill_abort, busy, inv_valid, msg_valid, msg_is_commit;
  logic [NODES-1:0] killers;
  logic [LW-1:0] inv_line;

  always #2.5 clk = ~clk;

  txn_conflict_tracker #(.NODES(NODES), .NODE_ID(ID), .LINES(LINES)) u0 (.*);

  int total = 0, bad = 0, inv_seen = 0;
  bit m_sr[LINES], m_sw[LINES], m_rc[LINES], m_k[NODES];
  bit m_busy, m_abort, m_msg, m_msgc, m_kill;
  int m_ptr;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kmask();
    int v = 0;
    for (int i = 0; i < NODES; i++) if (m_k[i]) v |= (1 << i);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_sr[i]) begin m_sr[i] = 0; m_sw[i] = 0; m_rc[i] = 0; end
      foreach (m_k[i]) m_k[i] = 0;
      m_busy = 0; m_abort = 0; m_msg = 0; m_msgc = 0; m_kill = 0; m_ptr = 0;
    end else begin
      bit rem, kl, fa, fc;
      rem = bus_valid && int'(bus_node) != ID;
      kl = !m_busy && rem && bus_is_commit && m_k[bus_node];
      fa = !m_busy && (end_abort || kl);
      fc = !m_busy && end_commit && !fa;
      m_msg = fa || fc; m_msgc = fc; m_kill = kl;
      if (m_busy) begin
        m_sr[m_ptr] = 0; m_sw[m_ptr] = 0; m_rc[m_ptr] = 0;
        if (m_ptr == LINES - 1) m_busy = 0; else m_ptr++;
      end else if (fa || fc) begin
        m_busy = 1; m_ptr = 0; m_abort = fa;
        foreach (m_k[i]) m_k[i] = 0;
      end else begin
        if (rem && !bus_is_commit) m_k[bus_node] = 0;
        if (acc_valid) begin
          if (acc_store) m_sw[acc_line] = 1; else m_sr[acc_line] = 1;
          if (acc_wconf && int'(acc_wconf_node) != ID) begin
            m_k[acc_wconf_node] = 1;
            if (!acc_store) m_rc[acc_line] = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit ei;
    ei = m_busy && (m_rc[m_ptr] || (m_abort && m_sw[m_ptr]));
    chk("R2 probe_sr", probe_sr, m_sr[probe_line]);
    chk("R2 probe_sw", probe_sw, m_sw[probe_line]);
    chk("R3 probe_rc", probe_rc, m_rc[probe_line]);
    chk("R3 killers", killers, kmask());
    chk("R4 kill_abort", kill_abort, m_kill);
    chk("R7 msg_valid", msg_valid, m_msg);
    if (m_msg) chk("R7 msg_is_commit", msg_is_commit, m_msgc);
    chk("R10 busy", busy, m_busy);
    chk("R8 inv_valid", inv_valid, ei);
    if (ei) begin chk("R8 inv_line", inv_line, m_ptr); inv_seen++; end
    probe_line <= probe_line + 1'b1;
  end

  task automatic cyc();
    @(posedge clk); #1;
    acc_valid = 0; acc_wconf = 0; end_commit = 0; end_abort = 0; bus_valid = 0;
  endtask

  task automatic acc(bit st, int ln, bit wc, int nd);
    acc_valid = 1; acc_store = st; acc_line = LW'(ln); acc_wconf = wc; acc_wconf_node = NW'(nd);
    cyc();
  endtask

  task automatic bus(bit c, int nd);
    bus_valid = 1; bus_is_commit = c; bus_node = NW'(nd);
    cyc();
  endtask

  task automatic probe(int ln, int exp_sr, int exp_sw, int exp_rc, string tag);
    @(posedge clk); #0.5;
    force probe_line = LW'(ln); #0.5;
    chk({tag, " sr"}, probe_sr, exp_sr);
    chk({tag, " sw"}, probe_sw, exp_sw);
    chk({tag, " rc"}, probe_rc, exp_rc);
    release probe_line;
  endtask

  task automatic drain();
    while (busy) cyc();
    cyc();
  endtask

  initial begin
    #(5.0 * 200000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 killers", killers, 0);
    chk("R1 msg", msg_valid, 0);
    chk("R1 inv", inv_valid, 0);
    chk("R1 kill", kill_abort, 0);
    probe(0, 0, 0, 0, "R1");
    cyc();

    acc(0, 2, 0, 0);
    acc(1, 5, 0, 0);
    probe(2, 1, 0, 0, "R2 load");
    probe(5, 0, 1, 0, "R2 store");
    acc(0, 3, 1, 2);
    acc(1, 6, 1, 3);
    chk("R3 map", killers, 4'b1100);
    probe(3, 1, 0, 1, "R3 load conf");
    probe(6, 0, 1, 0, "R3 store conf");
    acc(1, 7, 1, ID);
    chk("R6 own conflict", killers, 4'b1100);
    bus(0, 3);
    chk("R5 clear", killers, 4'b0100);
    bus(1, ID);
    chk("R6 own commit kill", kill_abort, 0);
    chk("R6 own commit msg", msg_valid, 0);
    bus(1, 0);
    chk("R4 no kill", kill_abort, 0);
    chk("R4 no msg", msg_valid, 0);
    inv_seen = 0;
    end_commit = 1; cyc();
    chk("R7 commit msg", msg_valid, 1);
    chk("R7 commit kind", msg_is_commit, 1);
    acc(1, 0, 1, 3);
    end_abort = 1; cyc();
    chk("R10 ignored", msg_valid, 0);
    drain();
    chk("R8 commit invals", inv_seen, 1);
    chk("R9 killers", killers, 0);
    for (int i = 0; i < LINES; i++) probe(i, 0, 0, 0, "R9");

    acc(1, 1, 0, 0);
    acc(0, 4, 1, 0);
    acc(1, 4, 0, 0);
    inv_seen = 0;
    end_commit = 1; bus_valid = 1; bus_is_commit = 1; bus_node = 0; cyc();
    chk("R11 kill", kill_abort, 1);
    chk("R11 abort kind", msg_is_commit, 0);
    drain();
    chk("R8 abort invals", inv_seen, 2);

    acc(0, 2, 1, 2);
    acc_valid = 1; acc_store = 0; acc_line = 3; acc_wconf = 1; acc_wconf_node = 2;
    bus_valid = 1; bus_is_commit = 0; bus_node = 2; cyc();
    chk("R5 set wins", killers, 4'b0100);
    inv_seen = 0;
    end_commit = 1; end_abort = 1; cyc();
    chk("R7 both kind", msg_is_commit, 0);
    drain();
    chk("R8 abort rc", inv_seen, 2);

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      acc_valid = r < 50; acc_store = $urandom_range(0, 1); acc_line = LW'($urandom);
      acc_wconf = $urandom_range(0, 2) == 0; acc_wconf_node = NW'($urandom);
      bus_valid = $urandom_range(0, 7) == 0; bus_is_commit = $urandom_range(0, 1);
      bus_node = NW'($urandom);
      end_commit = $urandom_range(0, 40) == 0; end_abort = $urandom_range(0, 80) == 0;
      cyc();
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule